// File: doc/BRIEF.md
# Banked Byte Register File with Stack Pointer and Condition Evaluator

This block is the working register store of a small CPU that handles 8-bit and 16-bit operands. Thirty-two byte registers are arranged as four banks of eight. The program status byte selects which bank the named register codes reach. Eight single-byte names and four 16-bit pair names give access to the selected bank. Beside the banks sit a 16-bit stack pointer and four byte-wide special registers, one of which is the status byte. The decode logic drives one write port and two independent read ports with a 5-bit register code. A separate window reads any of the 32 bytes by absolute slot number, whatever bank is selected.

A combinational evaluator turns a 3-bit condition selector into a single taken or not-taken bit. It looks at the zero and carry flags of the status byte, or at a 16-bit operand supplied by the caller. Reads are combinational. Every write lands on the next rising clock edge. The reset is asynchronous and active-low. Its release passes through a two-stage synchronizer before it reaches the storage.

Top module: `banked_regfile`

## Requirements
- R1: The selected bank number is 2*PSW[5] + PSW[3]. Read and write codes use the bank held in PSW before the current clock edge. After a PSW write that changes bank, the new bank applies from the following cycle.
- R2: Window slot s (win_addr = s) returns byte offset s mod 8 of bank 3 - (s div 8). Bank 0 therefore lies in slots 24..31 and bank 3 in slots 0..7.
- R3: Byte codes 1..8 name offsets 0..7 of the selected bank: X=1, A=2, C=3, B=4, E=5, D=6, L=7, H=8. A byte write stores wr_data[7:0] and ignores the upper byte. A byte read returns the byte zero-extended to 16 bits.
- R4: Pair codes are AX=9, BC=10, DE=11 and HL=12. Pair p = code-9 has its low byte at offset 2p and its high byte at offset 2p+1, so A, B, D and H are the high halves. Pair reads and pair writes both use this split.
- R5: Code 13 is the 16-bit stack pointer. A write to it always stores wr_data with bit 0 cleared.
- R6: After reset, all 32 bank bytes read 0x11. PSW reads 0x06, ES reads 0x0F, CS and PMC read 0x00, and the stack pointer reads 0x0000.
- R7: The value of cond_sel chooses the condition (CY = PSW[0], Z = PSW[6]):
  - 0: cond_val != 0
  - 1: cond_val == 0
  - 2: CY
  - 3: !CY
  - 4: Z
  - 5: !Z
  - 6: !(Z|CY)
  - 7: Z|CY
- R8: Code 0 is "none". It reads as 0, and a write to it changes no state. Codes 18..31 are undefined and must never be used for a write or a read; an assertion reports any such use.
- R9: A read that names a register written in the same cycle returns the old value. The written value is readable from the next cycle on.
- R10: The byte special registers are PSW=14, CS=15, ES=16 and PMC=17. Each stores wr_data[7:0] and reads zero-extended.
- R11: The two read ports work independently and can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 5 | Register code to write |
| wr_data | input | 16 | Write value (low byte for 8-bit targets) |
| rd0_reg | input | 5 | Register code for read port 0 |
| rd0_data | output | 16 | Read port 0 value |
| rd1_reg | input | 5 | Register code for read port 1 |
| rd1_data | output | 16 | Read port 1 value |
| win_addr | input | 5 | Absolute byte slot for the window |
| win_data | output | 8 | Byte at the window slot |
| cond_sel | input | 3 | Condition selector |
| cond_val | input | 16 | Operand for the value-tested conditions |
| cond_true | output | 1 | Condition result |

## Verification
Read data, window data and the condition result follow their select inputs in the same cycle. The bench therefore sets a select and compares one time unit later, well before the next edge. A write becomes visible one rising edge after it is presented, and a bank change becomes visible at that same edge. The bench drives each write on a falling edge and compares at the next falling edge. Two checks compare within the cycle of the write itself, to confirm that the old value is still seen: the same-cycle read and the bank switch. Because reset release takes two extra edges through the synchronizer, the bench waits several cycles before its first write.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int BYTE_W        = 8;
  localparam int WORD_W        = 16;
  localparam int CODE_W        = 5;
  localparam int NUM_BANKS     = 4;
  localparam int REGS_PER_BANK = 8;
  localparam int BANK_W        = $clog2(NUM_BANKS);
  localparam int OFF_W         = $clog2(REGS_PER_BANK);
  localparam int SLOTS         = NUM_BANKS * REGS_PER_BANK;
  localparam int SLOT_W        = $clog2(SLOTS);

  localparam int PSW_CY   = 0;
  localparam int PSW_RBS0 = 3;
  localparam int PSW_RBS1 = 5;
  localparam int PSW_Z    = 6;

  typedef enum logic [CODE_W-1:0] {
    RC_NONE = 5'd0,
    RC_X    = 5'd1,
    RC_A    = 5'd2,
    RC_C    = 5'd3,
    RC_B    = 5'd4,
    RC_E    = 5'd5,
    RC_D    = 5'd6,
    RC_L    = 5'd7,
    RC_H    = 5'd8,
    RC_AX   = 5'd9,
    RC_BC   = 5'd10,
    RC_DE   = 5'd11,
    RC_HL   = 5'd12,
    RC_SP   = 5'd13,
    RC_PSW  = 5'd14,
    RC_CS   = 5'd15,
    RC_ES   = 5'd16,
    RC_PMC  = 5'd17
  } reg_code_e;

  localparam logic [CODE_W-1:0] RC_LAST = 5'd17;

  typedef enum logic [2:0] {
    CND_T  = 3'd0,
    CND_F  = 3'd1,
    CND_C  = 3'd2,
    CND_NC = 3'd3,
    CND_Z  = 3'd4,
    CND_NZ = 3'd5,
    CND_H  = 3'd6,
    CND_NH = 3'd7
  } cond_e;

  typedef struct packed {
    logic [WORD_W-1:0] sp;
    logic [BYTE_W-1:0] psw;
    logic [BYTE_W-1:0] cs;
    logic [BYTE_W-1:0] es;
    logic [BYTE_W-1:0] pmc;
  } spec_regs_t;

  localparam logic [BYTE_W-1:0] BANK_RESET_BYTE = 8'h11;
  localparam spec_regs_t SPEC_RESET = '{sp: 16'h0000, psw: 8'h06, cs: 8'h00,
                                        es: 8'h0F, pmc: 8'h00};
endpackage

// File: rtl/rf_bank_array.sv
module rf_bank_array
  import rf_pkg::*;
#(
  parameter int NB  = NUM_BANKS,
  parameter int NR  = REGS_PER_BANK,
  parameter int BW  = BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_lo,
  input  logic [$clog2(NB*NR)-1:0]  idx_lo,
  input  logic [BW-1:0]             d_lo,
  input  logic                      we_hi,
  input  logic [$clog2(NB*NR)-1:0]  idx_hi,
  input  logic [BW-1:0]             d_hi,
  output logic [NB*NR*BW-1:0]       flat
);
  localparam int NSLOT = NB * NR;
  localparam int IW    = $clog2(NSLOT);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [BW-1:0] q;
    logic [BW-1:0] nxt;
    logic          hit_lo;
    logic          hit_hi;
    logic          en;

    assign hit_lo = we_lo && (idx_lo == IW'(g));
    assign hit_hi = we_hi && (idx_hi == IW'(g));
    assign en     = hit_lo || hit_hi;

    always_comb begin
      nxt = q;
      if (hit_hi) nxt = d_hi;
      if (hit_lo) nxt = d_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= BANK_RESET_BYTE;
      else if (en) q <= nxt;
    end

    assign flat[g*BW +: BW] = q;
  end
endmodule

// File: rtl/rf_special.sv
module rf_special
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [WORD_W-1:0] wr_data,
  output spec_regs_t        regs
);
  spec_regs_t q;
  spec_regs_t nxt;
  logic       en;

  always_comb begin
    nxt = q;
    en  = 1'b0;
    if (wr_en) begin
      case (wr_code)
        RC_SP:   begin nxt.sp  = {wr_data[WORD_W-1:1], 1'b0}; en = 1'b1; end
        RC_PSW:  begin nxt.psw = wr_data[BYTE_W-1:0];         en = 1'b1; end
        RC_CS:   begin nxt.cs  = wr_data[BYTE_W-1:0];         en = 1'b1; end
        RC_ES:   begin nxt.es  = wr_data[BYTE_W-1:0];         en = 1'b1; end
        RC_PMC:  begin nxt.pmc = wr_data[BYTE_W-1:0];         en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= SPEC_RESET;
    else if (en) q <= nxt;
  end

  assign regs = q;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
(
  input  logic [CODE_W-1:0]       code,
  input  logic [BANK_W-1:0]       bank,
  input  logic [SLOTS*BYTE_W-1:0] flat,
  input  spec_regs_t              regs,
  output logic [WORD_W-1:0]       data
);
  logic [BANK_W-1:0] slot_bank;
  logic [OFF_W-1:0]  byte_off;
  logic [1:0]        pair_idx;
  logic [SLOT_W-1:0] idx_byte;
  logic [SLOT_W-1:0] idx_lo;
  logic [SLOT_W-1:0] idx_hi;
  logic [BYTE_W-1:0] b_single;
  logic [BYTE_W-1:0] b_lo;
  logic [BYTE_W-1:0] b_hi;

  always_comb begin
    slot_bank = ~bank;
    byte_off  = OFF_W'(code - 5'd1);
    pair_idx  = 2'(code - 5'd9);
    idx_byte  = {slot_bank, byte_off};
    idx_lo    = {slot_bank, pair_idx, 1'b0};
    idx_hi    = {slot_bank, pair_idx, 1'b1};
    b_single  = flat[{idx_byte, 3'b000} +: BYTE_W];
    b_lo      = flat[{idx_lo, 3'b000} +: BYTE_W];
    b_hi      = flat[{idx_hi, 3'b000} +: BYTE_W];
  end

  always_comb begin
    data = '0;
    case (code)
      RC_X, RC_A, RC_C, RC_B,
      RC_E, RC_D, RC_L, RC_H:  data = {8'h00, b_single};
      RC_AX, RC_BC, RC_DE,
      RC_HL:                   data = {b_hi, b_lo};
      RC_SP:                   data = regs.sp;
      RC_PSW:                  data = {8'h00, regs.psw};
      RC_CS:                   data = {8'h00, regs.cs};
      RC_ES:                   data = {8'h00, regs.es};
      RC_PMC:                  data = {8'h00, regs.pmc};
      default:                 data = '0;
    endcase
  end
endmodule

// File: rtl/rf_cond_eval.sv
module rf_cond_eval
  import rf_pkg::*;
(
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] val,
  input  logic              flag_z,
  input  logic              flag_cy,
  output logic              taken
);
  logic val_nz;
  logic z_or_cy;

  assign val_nz  = |val;
  assign z_or_cy = flag_z | flag_cy;

  always_comb begin
    case (cond_e'(sel))
      CND_T:   taken = val_nz;
      CND_F:   taken = ~val_nz;
      CND_C:   taken = flag_cy;
      CND_NC:  taken = ~flag_cy;
      CND_Z:   taken = flag_z;
      CND_NZ:  taken = ~flag_z;
      CND_H:   taken = ~z_or_cy;
      default: taken = z_or_cy;
    endcase
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_reg,
  input  logic [15:0]       wr_data,
  input  logic [4:0]        rd0_reg,
  output logic [15:0]       rd0_data,
  input  logic [4:0]        rd1_reg,
  output logic [15:0]       rd1_data,
  input  logic [4:0]        win_addr,
  output logic [7:0]        win_data,
  input  logic [2:0]        cond_sel,
  input  logic [15:0]       cond_val,
  output logic              cond_true
);
  localparam int NUM_RD = 2;

  // reset: asserted asynchronously, released through two stages
  logic rst_s0, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s0    <= 1'b1;
      rst_int_n <= rst_s0;
    end
  end

  spec_regs_t              spec;
  logic [BYTE_W-1:0]       psw_q;
  logic [BANK_W-1:0]       bank;
  logic [SLOTS*BYTE_W-1:0] flat;

  assign psw_q = spec.psw;
  assign bank  = {psw_q[PSW_RBS1], psw_q[PSW_RBS0]};

  // write decode into bank slots
  logic              we_lo, we_hi;
  logic [SLOT_W-1:0] idx_lo, idx_hi;
  logic [BYTE_W-1:0] d_lo, d_hi;
  logic [BANK_W-1:0] wslot_bank;
  logic [1:0]        wpair;
  logic [OFF_W-1:0]  woff;

  always_comb begin
    wslot_bank = ~bank;
    woff       = OFF_W'(wr_reg - 5'd1);
    wpair      = 2'(wr_reg - 5'd9);
    we_lo      = 1'b0;
    we_hi      = 1'b0;
    idx_lo     = {wslot_bank, woff};
    idx_hi     = {wslot_bank, wpair, 1'b1};
    d_lo       = wr_data[BYTE_W-1:0];
    d_hi       = wr_data[WORD_W-1:BYTE_W];
    if (wr_en) begin
      case (wr_reg)
        RC_X, RC_A, RC_C, RC_B,
        RC_E, RC_D, RC_L, RC_H: we_lo = 1'b1;
        RC_AX, RC_BC, RC_DE, RC_HL: begin
          we_lo  = 1'b1;
          we_hi  = 1'b1;
          idx_lo = {wslot_bank, wpair, 1'b0};
        end
        default: ;
      endcase
    end
  end

  rf_bank_array u_banks (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_lo  (we_lo),
    .idx_lo (idx_lo),
    .d_lo   (d_lo),
    .we_hi  (we_hi),
    .idx_hi (idx_hi),
    .d_hi   (d_hi),
    .flat   (flat)
  );

  rf_special u_spec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_code (wr_reg),
    .wr_data (wr_data),
    .regs    (spec)
  );

  logic [NUM_RD-1:0][CODE_W-1:0] rd_code;
  logic [NUM_RD-1:0][WORD_W-1:0] rd_val;
  assign rd_code[0] = rd0_reg;
  assign rd_code[1] = rd1_reg;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port u_rp (
      .code (rd_code[p]),
      .bank (bank),
      .flat (flat),
      .regs (spec),
      .data (rd_val[p])
    );
  end

  assign rd0_data = rd_val[0];
  assign rd1_data = rd_val[1];
  assign win_data = flat[{win_addr, 3'b000} +: BYTE_W];

  rf_cond_eval u_cond (
    .sel     (cond_sel),
    .val     (cond_val),
    .flag_z  (psw_q[PSW_Z]),
    .flag_cy (psw_q[PSW_CY]),
    .taken   (cond_true)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_reg,
  input logic [15:0] wr_data,
  input logic [4:0]  rd0_reg,
  input logic [15:0] rd0_data,
  input logic [4:0]  rd1_reg,
  input logic [4:0]  win_addr,
  input logic [7:0]  win_data,
  input logic [2:0]  cond_sel,
  input logic        cond_true,
  input logic [7:0]  psw
);
  // R8: only defined codes may be used
  a_r8_wr_code_defined: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_reg <= RC_LAST));

  a_r8_rd_code_defined: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_reg <= RC_LAST) && (rd1_reg <= RC_LAST));

  // R5: stack pointer reads back even
  a_r5_sp_even: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == RC_SP) |=>
      (rd0_reg != RC_SP || rd0_data == {$past(wr_data[15:1]), 1'b0}));

  // R4: pair write reads back whole
  a_r4_pair_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg >= RC_AX && wr_reg <= RC_HL) |=>
      (rd0_reg != $past(wr_reg) || rd0_data == $past(wr_data)));

  // R7: zero flag condition follows a status write
  a_r7_z_after_psw: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == RC_PSW) |=>
      (cond_sel != CND_Z || cond_true == $past(wr_data[PSW_Z])));

  // R2: named read and window agree on register A
  a_r2_window_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_reg == RC_A && win_addr == {~psw[PSW_RBS1], ~psw[PSW_RBS0], 3'd1})
      |-> (rd0_data == {8'h00, win_data}));
endmodule

bind banked_regfile rf_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .wr_en     (wr_en),
  .wr_reg    (wr_reg),
  .wr_data   (wr_data),
  .rd0_reg   (rd0_reg),
  .rd0_data  (rd0_data),
  .rd1_reg   (rd1_reg),
  .win_addr  (win_addr),
  .win_data  (win_data),
  .cond_sel  (cond_sel),
  .cond_true (cond_true),
  .psw       (psw_q)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_reg;
  logic [15:0] wr_data;
  logic [4:0]  rd0_reg, rd1_reg;
  logic [15:0] rd0_data, rd1_data;
  logic [4:0]  win_addr;
  logic [7:0]  win_data;
  logic [2:0]  cond_sel;
  logic [15:0] cond_val;
  logic        cond_true;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd0_reg(rd0_reg), .rd0_data(rd0_data), .rd1_reg(rd1_reg), .rd1_data(rd1_data),
    .win_addr(win_addr), .win_data(win_data), .cond_sel(cond_sel),
    .cond_val(cond_val), .cond_true(cond_true)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] code, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = code; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] bank_psw(input int b);
    return 8'h06 | (((b >> 1) & 1) != 0 ? 8'h20 : 8'h00) | ((b & 1) != 0 ? 8'h08 : 8'h00);
  endfunction

  function automatic logic [7:0] pat(input int b, input int k);
    return 8'(8'hA0 + b * 16 + k);
  endfunction

  function automatic logic exp_cond(input int sel, input logic z, input logic cy,
                                    input logic [15:0] v);
    case (sel)
      0: return v != 0;
      1: return v == 0;
      2: return cy;
      3: return !cy;
      4: return z;
      5: return !z;
      6: return !(z || cy);
      default: return z || cy;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_reg = 5'd0; wr_data = 16'h0;
    rd0_reg = 5'd0; rd1_reg = 5'd0; win_addr = 5'd0; cond_sel = 3'd0; cond_val = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: reset values
    for (int s = 0; s < 32; s++) begin
      win_addr = 5'(s); #1;
      check("R6 bank byte reset", {8'h00, win_data}, 16'h0011);
    end
    rd0_reg = 5'd14; rd1_reg = 5'd16; #1;
    check("R6 PSW reset", rd0_data, 16'h0006);
    check("R6 ES reset", rd1_data, 16'h000F);
    rd0_reg = 5'd15; rd1_reg = 5'd17; #1;
    check("R6 CS reset", rd0_data, 16'h0000);
    check("R6 PMC reset", rd1_data, 16'h0000);
    rd0_reg = 5'd13; rd1_reg = 5'd1; #1;
    check("R6 SP reset", rd0_data, 16'h0000);
    check("R6 X reset", rd1_data, 16'h0011);

    // R8: none reads 0, write to none is ignored
    wr(5'd0, 16'hFFFF);
    rd0_reg = 5'd0; #1;
    check("R8 none reads zero", rd0_data, 16'h0000);
    for (int s = 0; s < 32; s++) begin
      win_addr = 5'(s); #1;
      check("R8 none write ignored bytes", {8'h00, win_data}, 16'h0011);
    end
    rd0_reg = 5'd14; rd1_reg = 5'd13; #1;
    check("R8 none write ignored PSW", rd0_data, 16'h0006);
    check("R8 none write ignored SP", rd1_data, 16'h0000);

    // R1 R3: fill every bank through byte codes, upper data byte is junk
    for (int b = 0; b < 4; b++) begin
      wr(5'd14, {8'h00, bank_psw(b)});
      for (int k = 0; k < 8; k++) wr(5'(k + 1), {8'hEE, pat(b, k)});
    end
    // R2: window sees bank n at slots (3-n)*8 + k
    for (int s = 0; s < 32; s++) begin
      win_addr = 5'(s); #1;
      check("R2 window slot mapping", {8'h00, win_data}, {8'h00, pat(3 - s / 8, s % 8)});
    end
    // R1 R3: named byte reads per bank, zero-extended
    for (int b = 0; b < 4; b++) begin
      wr(5'd14, {8'h00, bank_psw(b)});
      for (int k = 0; k < 8; k++) begin
        rd1_reg = 5'(k + 1); #1;
        check("R1 R3 byte read in bank", rd1_data, {8'h00, pat(b, k)});
      end
    end

    // R4: pairs in bank 2
    wr(5'd14, {8'h00, bank_psw(2)});
    for (int p = 0; p < 4; p++)
      wr(5'(9 + p), {8'(8'h31 + p), 8'(8'h70 + p)});
    for (int p = 0; p < 4; p++) begin
      rd0_reg = 5'(9 + p); rd1_reg = 5'(2 + 2 * p); win_addr = 5'(8 + 2 * p); #1;
      check("R4 pair read", rd0_data, {8'(8'h31 + p), 8'(8'h70 + p)});
      check("R4 pair high byte", rd1_data, {8'h00, 8'(8'h31 + p)});
      check("R4 pair low byte slot", {8'h00, win_data}, {8'h00, 8'(8'h70 + p)});
    end

    // R9: same-cycle write and read of A (bank 2, A = 0x31)
    @(negedge clk);
    wr_en = 1'b1; wr_reg = 5'd2; wr_data = 16'h005A; rd0_reg = 5'd2; #1;
    check("R9 same-cycle read old", rd0_data, 16'h0031);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R9 next-cycle read new", rd0_data, 16'h005A);

    // R1: bank switch 2 -> 1 visible one cycle later
    @(negedge clk);
    wr_en = 1'b1; wr_reg = 5'd14; wr_data = {8'h00, bank_psw(1)}; rd0_reg = 5'd1; #1;
    check("R1 old bank during PSW write", rd0_data, 16'h0070);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R1 new bank after PSW write", rd0_data, {8'h00, pat(1, 0)});

    // R5: stack pointer forced even
    wr(5'd13, 16'h1235);
    rd0_reg = 5'd13; #1;
    check("R5 SP odd write", rd0_data, 16'h1234);
    wr(5'd13, 16'hFFFF); #1;
    check("R5 SP all ones", rd0_data, 16'hFFFE);
    wr(5'd13, 16'h8002); #1;
    check("R5 SP even write", rd0_data, 16'h8002);

    // R10 R11: special bytes and independent ports
    wr(5'd15, 16'hAB5C);
    wr(5'd16, 16'hCD07);
    wr(5'd17, 16'hEF99);
    rd0_reg = 5'd15; rd1_reg = 5'd13; #1;
    check("R10 CS write", rd0_data, 16'h005C);
    check("R11 port1 independent", rd1_data, 16'h8002);
    rd0_reg = 5'd16; rd1_reg = 5'd17; #1;
    check("R10 ES write", rd0_data, 16'h0007);
    check("R10 PMC write", rd1_data, 16'h0099);

    // R7: condition sweep over flags, selectors and operand values
    for (int f = 0; f < 4; f++) begin
      logic z, cy;
      z = f[1]; cy = f[0];
      wr(5'd14, {1'b0, z, 5'b00000, cy});
      for (int sel = 0; sel < 8; sel++) begin
        for (int vi = 0; vi < 3; vi++) begin
          logic [15:0] v;
          v = (vi == 0) ? 16'h0000 : (vi == 1) ? 16'h0001 : 16'h8000;
          cond_sel = 3'(sel); cond_val = v; #1;
          check("R7 condition result", {15'h0, cond_true}, {15'h0, exp_cond(sel, z, cy, v)});
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule